// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C target that gives an external bus controller read and write access to a bank of 8-bit registers inside the chip. It samples SCL and SDA into the system clock domain through two-flop synchronisers and detects start, repeated start and stop conditions from them. It also matches a fixed 7-bit device address and handles SDA as an open-drain line: the block either pulls SDA low or lets it go, and never drives it high.

Access goes through an 8-bit register pointer. In a write transfer, the first byte after the address loads the pointer. Each byte after that is stored at the pointed register, and the pointer then steps forward by one. To read, the controller first sets the pointer in a write phase, then issues a repeated start and the device address with the read bit set. The target then returns the pointed register. Each byte the controller acknowledges advances the pointer, and a not-acknowledge ends the read. The register contents are presented on a flat output bus for the surrounding logic.

Top module: `i2c_reg_target`

## Requirements
- R1: An address byte whose upper seven bits equal `DEV_ADDR` is acknowledged: SDA is pulled low during the 9th SCL clock. Any other address gets no acknowledge, and every later byte is ignored until the next start or stop, so no register changes.
- R2: In a write transfer (bit 0 of the address byte = 0), the first following byte is loaded into the pointer. Each later byte is written to the register at the pointer, the pointer increments, and every such byte is acknowledged.
- R3: After a repeated start and a matching address with bit 0 = 1, the target sends the register at the pointer, most significant bit first.
- R4: When the controller acknowledges a read byte (SDA low on the 9th clock), the pointer increments and the next register is sent. When it does not acknowledge (SDA high), the pointer stays where it is and the target keeps SDA released until the next start.
- R5: The pointer is 8 bits and wraps from 0xFF to 0x00. Pointer values of `NUM_REGS` or more read as 0x00, and writes to them have no effect.
- R6: The pointer value survives a stop, so a read that does not set the pointer first continues from the held value.
- R7: A start or stop that arrives before the 8th bit of a byte abandons that byte without writing any register. After a start the target expects an address; after a stop it is idle.
- R8: The target begins pulling SDA low only while SCL is low.
- R9: After reset, SDA is released, every register reads 0x00 and the pointer is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level, as seen on the wired bus |
| sda_drive_low | output | 1 | 1 = pull SDA low, 0 = release |
| reg_q | output | NUM_REGS*8 | Register contents; register k occupies bits [8k+7:8k] |

## Verification
The bench targets the following corner cases:
- **Address sweep.** It offers every wrong device address. A faulty comparator would acknowledge one of them, or let the bytes that follow land in the registers.
- **Pointer wrap.** It writes and reads across 0xFF to 0x00 and past the last implemented register. A design that clipped the pointer or aliased the index would corrupt low registers or return stale data.
- **Read termination and stop.** It reads back after a not-acknowledge and after a stop. A target that stepped the pointer on the final byte, or cleared it at stop, would return the neighbouring register.
- **Aborted bytes.** It cuts bytes short with a stop and with a repeated start. A target that committed partial bytes would show the half-shifted value in a register.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;

    localparam int PTR_W  = 8;
    localparam int DATA_W = 8;
    localparam int BIT_CNT_W = $clog2(DATA_W);

    typedef enum logic [2:0] {
        PH_IDLE,        // not addressed, waits for start
        PH_RECV,        // shifting a byte in from the controller
        PH_ACK_SETUP,   // byte taken, pull SDA at next SCL fall
        PH_ACK_HOLD,    // holding ACK through 9th clock
        PH_SEND,        // shifting a byte out
        PH_SEND_LOAD,   // load next read byte at next SCL fall
        PH_MACK_SETUP,  // release SDA for the controller's ACK bit
        PH_MACK         // sample controller ACK/NACK
    } phase_e;

    typedef enum logic [1:0] {
        K_ADDR,
        K_PTR,
        K_DATA
    } kind_e;

    typedef struct packed {
        logic scl;      // synchronised SCL level
        logic sda;      // synchronised SDA level
        logic start;
        logic stop;
        logic rise;     // SCL rising edge
        logic fall;     // SCL falling edge
    } bus_ev_t;

    typedef struct packed {
        logic              en;
        logic [PTR_W-1:0]  addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic logic addr_hit(input logic [DATA_W-1:0] rx, input logic [6:0] dev);
        return rx[DATA_W-1:1] == dev;
    endfunction

endpackage

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
    import i2c_reg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_sh;
    logic [SYNC_STAGES-1:0] sda_sh;
    logic                   scl_d;
    logic                   sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[MSB-1:0], scl_i};
            sda_sh <= {sda_sh[MSB-1:0], sda_i};
            scl_d  <= scl_sh[MSB];
            sda_d  <= sda_sh[MSB];
        end
    end

    always_comb begin
        ev.scl   = scl_sh[MSB];
        ev.sda   = sda_sh[MSB];
        ev.start = scl_d && scl_sh[MSB] && sda_d && !sda_sh[MSB];
        ev.stop  = scl_d && scl_sh[MSB] && !sda_d && sda_sh[MSB];
        ev.rise  = !scl_d && scl_sh[MSB];
        ev.fall  = scl_d && !scl_sh[MSB];
    end

endmodule

// File: rtl/i2c_reg_file.sv
module i2c_reg_file
    import i2c_reg_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  wr_req_t                wr,
    input  logic [PTR_W-1:0]       rd_addr,
    output logic [DATA_W-1:0]      rd_data,
    output logic [NUM_REGS*8-1:0]  q
);
    logic [DATA_W-1:0] mem [NUM_REGS];

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[gi] <= '0;
            end else if (wr.en && wr.addr == PTR_W'(gi)) begin
                mem[gi] <= wr.data;
            end
        end
        assign q[gi*8 +: 8] = mem[gi];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == PTR_W'(i)) begin
                rd_data = mem[i];
            end
        end
    end

    AST_OOR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr.en && int'(wr.addr) >= NUM_REGS) |=> $stable(q)); // R5

endmodule

// File: rtl/i2c_xfer_fsm.sv
module i2c_xfer_fsm
    import i2c_reg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h52
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [DATA_W-1:0] rd_data,
    output wr_req_t           wr,
    output logic [PTR_W-1:0]  ptr,
    output logic              sda_oe
);
    phase_e                phase;
    kind_e                 kind;
    logic [BIT_CNT_W-1:0]  cnt;
    logic [DATA_W-1:0]     shreg;
    logic                  is_read;
    logic [DATA_W-1:0]     rx_byte;
    logic                  byte_done;
    logic                  ptr_load;

    assign rx_byte   = {shreg[DATA_W-2:0], ev.sda};
    assign byte_done = ev.rise && phase == PH_RECV && cnt == BIT_CNT_W'(DATA_W-1);
    assign ptr_load  = byte_done && kind == K_PTR;

    always_comb begin
        wr.en   = byte_done && kind == K_DATA;
        wr.addr = ptr;
        wr.data = rx_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            kind    <= K_ADDR;
            cnt     <= '0;
            shreg   <= '0;
            is_read <= 1'b0;
            ptr     <= '0;
            sda_oe  <= 1'b0;
        end else if (ev.start) begin
            phase  <= PH_RECV;
            kind   <= K_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else if (ev.stop) begin
            phase  <= PH_IDLE;
            sda_oe <= 1'b0;
        end else if (ev.rise) begin
            case (phase)
                PH_RECV: begin
                    shreg <= rx_byte;
                    cnt   <= cnt + 1'b1;
                    if (byte_done) begin
                        case (kind)
                            K_ADDR: begin
                                if (addr_hit(rx_byte, DEV_ADDR)) begin
                                    is_read <= rx_byte[0];
                                    phase   <= PH_ACK_SETUP;
                                end else begin
                                    phase <= PH_IDLE;
                                end
                            end
                            K_PTR: begin
                                ptr   <= rx_byte;
                                phase <= PH_ACK_SETUP;
                            end
                            default: begin
                                ptr   <= ptr + 1'b1;
                                phase <= PH_ACK_SETUP;
                            end
                        endcase
                    end
                end
                PH_SEND: begin
                    shreg <= {shreg[DATA_W-2:0], 1'b1};
                    cnt   <= cnt + 1'b1;
                    if (cnt == BIT_CNT_W'(DATA_W-1)) begin
                        phase <= PH_MACK_SETUP;
                    end
                end
                PH_MACK: begin
                    if (ev.sda) begin
                        phase <= PH_IDLE;
                    end else begin
                        ptr   <= ptr + 1'b1;
                        phase <= PH_SEND_LOAD;
                    end
                end
                default: ;
            endcase
        end else if (ev.fall) begin
            case (phase)
                PH_ACK_SETUP: begin
                    sda_oe <= 1'b1;
                    phase  <= PH_ACK_HOLD;
                end
                PH_ACK_HOLD: begin
                    cnt <= '0;
                    if (kind == K_ADDR && is_read) begin
                        shreg  <= rd_data;
                        sda_oe <= ~rd_data[DATA_W-1];
                        phase  <= PH_SEND;
                    end else begin
                        sda_oe <= 1'b0;
                        phase  <= PH_RECV;
                        kind   <= (kind == K_ADDR) ? K_PTR : K_DATA;
                    end
                end
                PH_SEND: begin
                    sda_oe <= ~shreg[DATA_W-1];
                end
                PH_SEND_LOAD: begin
                    cnt    <= '0;
                    shreg  <= rd_data;
                    sda_oe <= ~rd_data[DATA_W-1];
                    phase  <= PH_SEND;
                end
                PH_MACK_SETUP: begin
                    sda_oe <= 1'b0;
                    phase  <= PH_MACK;
                end
                default: ;
            endcase
        end
    end

    AST_OE_RISES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !ev.scl); // R8
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> !sda_oe); // R4
    AST_SEND_ONLY_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SEND) |-> is_read); // R3
    AST_PTR_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (rst)
        (ptr != $past(ptr) && !$past(ptr_load)) |-> ptr == PTR_W'($past(ptr) + 1'b1)); // R5

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2c_reg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h52,
    parameter int         NUM_REGS    = 16,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_drive_low,
    output logic [NUM_REGS*8-1:0] reg_q
);
    bus_ev_t           ev;
    wr_req_t           wr;
    logic [PTR_W-1:0]  ptr;
    logic [DATA_W-1:0] rd_data;

    i2c_bus_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_xfer_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .rd_data (rd_data),
        .wr      (wr),
        .ptr     (ptr),
        .sda_oe  (sda_drive_low)
    );

    i2c_reg_file #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .rd_addr (ptr),
        .rd_data (rd_data),
        .q       (reg_q)
    );

endmodule

// File: tb/i2c_reg_target_test.sv
module i2c_reg_target_test;
    localparam int         NR  = 16;
    localparam logic [6:0] DEV = 7'h52;
    localparam int         Q   = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_low;
    logic [NR*8-1:0] reg_q;
    wire  sda_line = m_sda & ~sda_low;

    always #5 clk = ~clk;

    i2c_reg_target #(.DEV_ADDR(DEV), .NUM_REGS(NR)) uut (
        .clk           (clk),
        .rst           (rst),
        .scl_i         (scl),
        .sda_i         (sda_line),
        .sda_drive_low (sda_low),
        .reg_q         (reg_q)
    );

    int n_vec = 0;
    int n_bad = 0;
    int oe_bad_rise = 0;
    logic oe_prev = 1'b0;
    logic [7:0] model [NR];
    logic [7:0] exp_ptr = 8'h00;

    // R8 monitor: pull-low must start while SCL is low
    always @(posedge clk) begin
        if (!rst && sda_low && !oe_prev && scl) oe_bad_rise <= oe_bad_rise + 1;
        oe_prev <= sda_low;
    end

    task automatic tq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mrd(input logic [7:0] p);
        return (p < NR) ? model[p[3:0]] : 8'h00;
    endfunction

    task automatic mwr(input logic [7:0] p, input logic [7:0] v);
        if (p < NR) model[p[3:0]] = v;
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < NR; i++)
            chk(reg_q[i*8 +: 8] == model[i], req, reg_q[i*8 +: 8], model[i]);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tq(); scl = 1'b1; tq(); m_sda = 1'b0; tq(); scl = 1'b0; tq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tq(); scl = 1'b1; tq(); m_sda = 1'b1; tq(); tq();
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; tq(); scl = 1'b1; tq(); tq(); scl = 1'b0; tq();
    endtask

    task automatic write_byte(input logic [7:0] b, output logic nack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; tq(); scl = 1'b1; tq(); nack = sda_line; tq(); scl = 1'b0; tq();
    endtask

    task automatic read_byte(input logic mnack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tq(); scl = 1'b1; tq(); b[i] = sda_line; tq(); scl = 1'b0;
        end
        tq();
        send_bit(mnack);
    endtask

    task automatic xfer_write(input logic [7:0] p, input int n, input logic [7:0] seed);
        logic a;
        bus_start();
        write_byte({DEV, 1'b0}, a); chk(a == 1'b0, "R1", a, 0);
        write_byte(p, a);           chk(a == 1'b0, "R2", a, 0);
        exp_ptr = p;
        for (int k = 0; k < n; k++) begin
            logic [7:0] d;
            d = seed + 8'(k * 29);
            write_byte(d, a); chk(a == 1'b0, "R2", a, 0);
            mwr(exp_ptr, d);
            exp_ptr = exp_ptr + 8'd1;
        end
        bus_stop();
    endtask

    task automatic xfer_read(input bit set_ptr, input logic [7:0] p, input int n, input string req);
        logic a;
        logic [7:0] d;
        bus_start();
        if (set_ptr) begin
            write_byte({DEV, 1'b0}, a); chk(a == 1'b0, "R1", a, 0);
            write_byte(p, a);           chk(a == 1'b0, "R2", a, 0);
            exp_ptr = p;
            bus_start();
        end
        write_byte({DEV, 1'b1}, a); chk(a == 1'b0, "R1", a, 0);
        for (int k = 0; k < n; k++) begin
            read_byte(k == n - 1, d);
            chk(d == mrd(exp_ptr), req, d, mrd(exp_ptr));
            if (k != n - 1) exp_ptr = exp_ptr + 8'd1;
        end
        chk(sda_low == 1'b0, "R4", sda_low, 0);
        bus_stop();
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        logic a;
        for (int i = 0; i < NR; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        tq();
        // R9: reset state
        chk(sda_low == 1'b0, "R9", sda_low, 0);
        check_regs("R9");
        xfer_read(1'b0, 8'h00, 1, "R9");

        // R1: every non-matching address is refused and ignored
        for (int ad = 0; ad < 128; ad++) begin
            if (7'(ad) == DEV) continue;
            bus_start();
            write_byte({7'(ad), 1'b0}, a);
            chk(a == 1'b1, "R1", a, 1);
            if (ad[3:0] == 4'd0) begin
                write_byte(8'h00, a);
                write_byte(8'hEE, a);
            end
            bus_stop();
        end
        check_regs("R1");

        // R2: burst write over whole bank, then single writes
        xfer_write(8'h00, NR, 8'h3C);
        check_regs("R2");
        for (int p = 0; p < NR; p += 3) xfer_write(8'(p), 1, 8'h80 + 8'(p));
        check_regs("R2");

        // R3: single-byte reads at every pointer
        for (int p = 0; p < NR; p++) xfer_read(1'b1, 8'(p), 1, "R3");

        // R4/R5: burst read running past the implemented registers
        xfer_read(1'b1, 8'(NR - 4), 7, "R4");

        // R5: burst write across 0xFF -> 0x00
        xfer_write(8'hFD, 5, 8'h11);
        check_regs("R5");
        // R6: read with no pointer write continues from held pointer
        xfer_read(1'b0, 8'h00, 1, "R6");
        // R5: burst read across wrap
        xfer_read(1'b1, 8'hFF, 3, "R5");

        // R6: NACK leaves pointer, stop keeps it
        xfer_read(1'b1, 8'h04, 2, "R6");
        xfer_read(1'b0, 8'h00, 1, "R6");

        // R7: stop in the middle of a data byte
        bus_start();
        write_byte({DEV, 1'b0}, a);
        write_byte(8'h09, a);
        for (int i = 7; i >= 4; i--) send_bit(8'hC3 >> i);
        bus_stop();
        check_regs("R7");

        // R7: repeated start in the middle of a data byte
        bus_start();
        write_byte({DEV, 1'b0}, a);
        write_byte(8'h0A, a);
        for (int i = 7; i >= 3; i--) send_bit(8'h77 >> i);
        bus_start();
        write_byte({DEV, 1'b0}, a); chk(a == 1'b0, "R7", a, 0);
        write_byte(8'h0B, a);
        write_byte(8'h99, a);
        mwr(8'h0B, 8'h99);
        bus_stop();
        check_regs("R7");

        // R8: pull-low never began while SCL was high
        chk(oe_bad_rise == 0, "R8", oe_bad_rise, 0);
        summary();
    end

endmodule